// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two component predictors and a selector. The bimodal component keeps 2-bit saturating counters indexed by the branch address alone. The gshare component keeps 2-bit saturating counters indexed by the branch address XORed with a global history of recent outcomes. A third table of 2-bit counters, also indexed by address, learns per branch which component to trust. Until the history register has been filled once after reset, the bimodal answer is always taken. This keeps a new loop from missing for many iterations while the gshare index is still moving from entry to entry.

The fetch side presents a branch word address (the address with the instruction-alignment bits already removed) on the lookup port. One cycle later the block returns the chosen direction, both component directions and which component was chosen. When the branch resolves, the pipeline returns the address, the real outcome and the two component directions it was given at lookup. All three tables then train, and the history register shifts in the outcome. Resolves are expected in program order, with no speculative history.

Top module: `tourney_bp`

## Requirements
- R1: After reset `pred_valid` is 0. Every counter in all three tables holds weakly not-taken (value 1 of 0..3), so the first lookup of any address returns `pred_taken`=0, `pred_bm_taken`=0, `pred_gs_taken`=0 and `pred_used_gs`=0.
- R2: `pred_valid` is 1 in the cycle after a cycle with `lookup_valid`=1 and 0 otherwise. The prediction outputs change only after a lookup.
- R3: The bimodal counter is selected by `res_pc`/`lookup_pc` directly. On a valid resolve it steps up by one on taken and down by one on not-taken, saturating at 3 and 0. Its direction is bit 1 of the counter (1 = taken).
- R4: The gshare counter is selected by the address XOR the 10-bit history, with the same counter rules as R3.
- R5: On each valid resolve, the history shifts left by one and `res_taken` (1 = taken) enters at bit 0. The counter updates of that resolve use the history from before the shift.
- R6: The chooser counter for the address selects gshare when its bit 1 is 1. On resolve it steps toward gshare when only `res_gs_taken` matched `res_taken`, steps toward bimodal when only `res_bm_taken` matched, and is unchanged otherwise.
- R7: Until 10 valid resolves have occurred since reset, `pred_used_gs` is 0 whatever the chooser holds. The chooser still trains during this period.
- R8: A resolve with `res_valid`=0 changes no table and no history.
- R9: When a lookup and a resolve occur in the same cycle, the prediction is formed from the tables and history as they were before that resolve.
- R10: `pred_taken` equals `pred_gs_taken` when `pred_used_gs`=1 and `pred_bm_taken` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid | input | 1 | Lookup request this cycle |
| lookup_pc | input | 10 | Branch word address to predict |
| res_valid | input | 1 | Resolve event this cycle |
| res_pc | input | 10 | Word address of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_gs_taken | input | 1 | Gshare direction given at lookup |
| res_bm_taken | input | 1 | Bimodal direction given at lookup |
| pred_valid | output | 1 | Prediction outputs refer to last cycle's lookup |
| pred_taken | output | 1 | Chosen direction |
| pred_gs_taken | output | 1 | Gshare component direction |
| pred_bm_taken | output | 1 | Bimodal component direction |
| pred_used_gs | output | 1 | 1 when gshare was chosen |

## Verification
A lookup and a resolve can land in the same cycle, and both can address the same counter and read the history that the resolve is about to shift. The bench provokes this by resolving a fresh address as taken while looking up that same address. It expects the old weakly-not-taken answer in that cycle, and it expects the trained answer on the following lookup. The reference model in the bench takes its snapshot before applying the update, so any change to history or gshare index ordering also shows up in the later model comparisons.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_WEAK_NT = 2'b01;
    localparam ctr2_t CTR_MAX     = 2'b11;
    localparam ctr2_t CTR_MIN     = 2'b00;

    // saturating step of a 2-bit counter
    function automatic ctr2_t ctr_step(ctr2_t c, logic up);
        ctr2_t r;
        if (up) r = (c == CTR_MAX) ? c : c + 2'd1;
        else    r = (c == CTR_MIN) ? c : c - 2'd1;
        return r;
    endfunction

    function automatic logic ctr_dir(ctr2_t c);
        return c[1];
    endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_dir,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_up
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        ctr2_t            val;
    } wr_t;

    ctr2_t mem_q [DEPTH];
    wr_t   wr_d;

    always_comb begin
        wr_d.en  = upd_en;
        wr_d.idx = upd_idx;
        wr_d.val = ctr_step(mem_q[upd_idx], upd_up);
        rd_dir   = ctr_dir(mem_q[rd_idx]);
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem_q[g] <= CTR_WEAK_NT;
                else if (wr_d.en && (wr_d.idx == IDX_W'(g)))
                    mem_q[g] <= wr_d.val;
            end
        end
    endgenerate

    // R3
    sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && upd_up && mem_q[upd_idx] == CTR_MAX) |=> mem_q[$past(upd_idx)] == CTR_MAX);
    // R3
    sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && !upd_up && mem_q[upd_idx] == CTR_MIN) |=> mem_q[$past(upd_idx)] == CTR_MIN);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> mem_q[$past(rd_idx)] == $past(mem_q[rd_idx]));

endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (shift_en) hist_d = {hist_q[HIST_W-2:0], shift_bit};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign hist = hist_q;

    // R5
    shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q == {$past(hist_q[HIST_W-2:0]), $past(shift_bit)});
    // R8
    still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_q));

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
    import bp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lookup_valid,
    input  logic [IDX_W-1:0] lookup_pc,
    input  logic             res_valid,
    input  logic [IDX_W-1:0] res_pc,
    input  logic             res_taken,
    input  logic             res_gs_taken,
    input  logic             res_bm_taken,
    output logic             pred_valid,
    output logic             pred_taken,
    output logic             pred_gs_taken,
    output logic             pred_bm_taken,
    output logic             pred_used_gs
);

    localparam int HIST_W = IDX_W;
    localparam int FILL_W = $clog2(HIST_W + 1);
    localparam logic [FILL_W-1:0] FILL_MAX = FILL_W'(HIST_W);

    typedef struct packed {
        logic              vld;
        logic              taken;
        logic              gs;
        logic              bm;
        logic              used_gs;
        logic [FILL_W-1:0] fill;
    } st_t;

    st_t st_d, st_q;

    logic [HIST_W-1:0] hist;
    logic              gs_dir, bm_dir, ch_dir;
    logic [IDX_W-1:0]  gs_rd_idx, gs_up_idx;
    logic              ch_upd_en, ch_upd_up;
    logic              warm;

    assign gs_rd_idx = lookup_pc ^ hist;
    assign gs_up_idx = res_pc ^ hist;
    assign ch_upd_en = res_valid && (res_gs_taken != res_bm_taken);
    assign ch_upd_up = (res_gs_taken == res_taken);
    assign warm      = (st_q.fill == FILL_MAX);

    bp_ctr_table #(.IDX_W(IDX_W)) u_bimodal (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lookup_pc), .rd_dir(bm_dir),
        .upd_en(res_valid), .upd_idx(res_pc), .upd_up(res_taken)
    );

    bp_ctr_table #(.IDX_W(IDX_W)) u_gshare (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(gs_rd_idx), .rd_dir(gs_dir),
        .upd_en(res_valid), .upd_idx(gs_up_idx), .upd_up(res_taken)
    );

    bp_ctr_table #(.IDX_W(IDX_W)) u_chooser (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lookup_pc), .rd_dir(ch_dir),
        .upd_en(ch_upd_en), .upd_idx(res_pc), .upd_up(ch_upd_up)
    );

    bp_ghist #(.HIST_W(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .shift_en(res_valid), .shift_bit(res_taken),
        .hist(hist)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = lookup_valid;
        if (lookup_valid) begin
            st_d.gs      = gs_dir;
            st_d.bm      = bm_dir;
            st_d.used_gs = warm && ch_dir;
            st_d.taken   = (warm && ch_dir) ? gs_dir : bm_dir;
        end
        if (res_valid && !warm) st_d.fill = st_q.fill + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pred_valid    = st_q.vld;
    assign pred_taken    = st_q.taken;
    assign pred_gs_taken = st_q.gs;
    assign pred_bm_taken = st_q.bm;
    assign pred_used_gs  = st_q.used_gs;

    // R2
    lat_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> pred_valid);
    // R2
    lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !pred_valid && $stable(pred_taken));
    // R7
    warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && !warm) |=> !pred_used_gs);
    // R10
    select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> pred_taken == (pred_used_gs ? pred_gs_taken : pred_bm_taken));

endmodule

// File: tb/tourney_bp_test.sv
`timescale 1ns/1ps
module tourney_bp_test;

    localparam int IW    = 10;
    localparam int DEPTH = 1 << IW;
    localparam int NVEC  = 16;

    // {taken, pc}
    localparam logic [IW:0] VEC [NVEC] = '{
        {1'b1, 10'd5}, {1'b1, 10'd5}, {1'b0, 10'd9}, {1'b1, 10'd5},
        {1'b0, 10'd9}, {1'b1, 10'd5}, {1'b1, 10'd9}, {1'b1, 10'd5},
        {1'b0, 10'd5}, {1'b1, 10'd9}, {1'b1, 10'd5}, {1'b0, 10'd9},
        {1'b1, 10'd5}, {1'b1, 10'd5}, {1'b0, 10'd9}, {1'b1, 10'd5}
    };

    logic clk = 0, rst_n = 0;
    logic lookup_valid = 0, res_valid = 0, res_taken = 0, res_gs_taken = 0, res_bm_taken = 0;
    logic [IW-1:0] lookup_pc = '0, res_pc = '0;
    logic pred_valid, pred_taken, pred_gs_taken, pred_bm_taken, pred_used_gs;

    int checks = 0, errors = 0;
    bit done = 0;

    logic [1:0] bm_m [DEPTH];
    logic [1:0] gs_m [DEPTH];
    logic [1:0] ch_m [DEPTH];
    logic [IW-1:0] ghr_m;
    int fill_m;
    logic e_taken, e_gs, e_bm, e_used;

    always #2.5 clk = ~clk;

    tourney_bp #(.IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n),
        .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_gs_taken(res_gs_taken), .res_bm_taken(res_bm_taken),
        .pred_valid(pred_valid), .pred_taken(pred_taken),
        .pred_gs_taken(pred_gs_taken), .pred_bm_taken(pred_bm_taken),
        .pred_used_gs(pred_used_gs)
    );

    function automatic logic [1:0] sat(logic [1:0] c, logic up);
        if (up) return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    task automatic check(logic act, logic exp, string req, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic model_expect(logic [IW-1:0] pc);
        e_bm   = bm_m[pc][1];
        e_gs   = gs_m[pc ^ ghr_m][1];
        e_used = (fill_m >= IW) && ch_m[pc][1];
        e_taken = e_used ? e_gs : e_bm;
    endtask

    task automatic model_resolve(logic [IW-1:0] pc, logic t, logic g, logic b);
        bm_m[pc] = sat(bm_m[pc], t);
        gs_m[pc ^ ghr_m] = sat(gs_m[pc ^ ghr_m], t);
        if (g != b) ch_m[pc] = sat(ch_m[pc], g == t);
        ghr_m = {ghr_m[IW-2:0], t};
        if (fill_m < IW) fill_m++;
    endtask

    task automatic check_pred(string req);
        check(pred_valid, 1'b1, req, "pred_valid");
        check(pred_taken, e_taken, req, "pred_taken");
        check(pred_gs_taken, e_gs, req, "pred_gs_taken");
        check(pred_bm_taken, e_bm, req, "pred_bm_taken");
        check(pred_used_gs, e_used, req, "pred_used_gs");
    endtask

    // called at a negedge
    task automatic lookup(logic [IW-1:0] pc, string req);
        model_expect(pc);
        lookup_valid = 1; lookup_pc = pc;
        @(negedge clk);
        lookup_valid = 0;
        check_pred(req);
    endtask

    task automatic resolve(logic [IW-1:0] pc, logic t, logic g, logic b);
        res_valid = 1; res_pc = pc; res_taken = t; res_gs_taken = g; res_bm_taken = b;
        @(negedge clk);
        res_valid = 0;
        model_resolve(pc, t, g, b);
    endtask

    task automatic train(logic [IW-1:0] pc, logic t, string req);
        lookup(pc, req);
        resolve(pc, t, pred_gs_taken, pred_bm_taken);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            bm_m[i] = 2'd1; gs_m[i] = 2'd1; ch_m[i] = 2'd1;
        end
        ghr_m = '0; fill_m = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check(pred_valid, 1'b0, "R1", "pred_valid after reset");
        lookup(10'd0, "R1");
        check(pred_taken, 1'b0, "R1", "first prediction literal");
        check(pred_used_gs, 1'b0, "R1", "first selection literal");
        // R2 valid drops when idle
        @(negedge clk);
        check(pred_valid, 1'b0, "R2", "pred_valid idle");

        // R7 chooser trained toward gshare during warm-up, still not used
        resolve(10'd3, 1'b1, 1'b1, 1'b0);
        resolve(10'd3, 1'b1, 1'b1, 1'b0);
        lookup(10'd3, "R7");
        check(pred_used_gs, 1'b0, "R7", "selection during warm-up");
        for (int i = 0; i < 8; i++) resolve(10'd100, 1'b0, 1'b0, 1'b0);
        // R6 after warm-up the chooser picks gshare
        lookup(10'd3, "R6");
        check(pred_used_gs, 1'b1, "R6", "selection after warm-up");

        // R6 chooser unchanged when components agree, moves toward bimodal
        resolve(10'd3, 1'b1, 1'b1, 1'b1);
        lookup(10'd3, "R6");
        check(pred_used_gs, 1'b1, "R6", "chooser held on agreement");
        resolve(10'd3, 1'b0, 1'b1, 1'b0);
        resolve(10'd3, 1'b0, 1'b1, 1'b0);
        lookup(10'd3, "R6");
        check(pred_used_gs, 1'b0, "R6", "chooser back to bimodal");

        // R8 resolve fields without valid change nothing
        res_pc = 10'd50; res_taken = 1; res_gs_taken = 0; res_bm_taken = 1;
        repeat (4) @(negedge clk);
        lookup(10'd50, "R8");
        check(pred_bm_taken, 1'b0, "R8", "bimodal untouched");

        // R3 R4 R5 R10 vector walk
        for (int i = 0; i < NVEC; i++)
            train(VEC[i][IW-1:0], VEC[i][IW], "R3,R4,R5,R10");

        // R3 saturation
        for (int i = 0; i < 4; i++) train(10'd40, 1'b1, "R3");
        resolve(10'd40, 1'b0, pred_gs_taken, pred_bm_taken);
        lookup(10'd40, "R3");
        check(pred_bm_taken, 1'b1, "R3", "saturated counter after one miss");
        resolve(10'd40, 1'b0, pred_gs_taken, pred_bm_taken);
        lookup(10'd40, "R3");
        check(pred_bm_taken, 1'b0, "R3", "counter after two misses");

        // R9 same-cycle lookup and resolve on a fresh address
        model_expect(10'd20);
        lookup_valid = 1; lookup_pc = 10'd20;
        res_valid = 1; res_pc = 10'd20; res_taken = 1; res_gs_taken = 0; res_bm_taken = 0;
        @(negedge clk);
        lookup_valid = 0; res_valid = 0;
        check_pred("R9");
        check(pred_bm_taken, 1'b0, "R9", "old bimodal value in collision");
        model_resolve(10'd20, 1'b1, 1'b0, 1'b0);
        lookup(10'd20, "R9");
        check(pred_bm_taken, 1'b1, "R9", "trained value after collision");

        // R4 R5 history-dependent gshare entries under alternating pattern
        for (int i = 0; i < 12; i++) train(10'd77, i[0], "R4,R5");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule